// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a data cache that sits between a processor's load/store port and a slower word-wide memory. Requests carry a physical byte address. The address splits into three fields: a tag in the upper bits, a set index below it, and a word offset within the line. The byte lane bits below the word offset are ignored. Each set holds a power-of-two number of ways, and each way holds a line of a power-of-two number of words. Every line has a valid flag and a dirty flag, and a hardware reset clears all valid flags.

A read that hits returns its word in the same cycle and does not stall. A write that hits updates the cached word and marks the line dirty. It causes no memory traffic. On a miss the processor is stalled while the controller handles the line. It picks the least recently used way of the set, but an invalid way is taken first. If that victim is dirty, the controller writes the whole line back in one burst. It then refills the line in a second burst. After the refill it spends one more stalled cycle before releasing the processor, whose retried access then hits. A write miss therefore refills the line before the store is applied.

The memory side uses a burst protocol. A one-cycle start pulse presents the line-aligned address, the word count and the direction. After that, one word moves on each cycle in which the memory raises its acknowledge. A done pulse closes the burst, in a cycle after the last word.

Top module: `sa_wb_cache`

## Requirements
- R1: After reset no line is valid, so the first access to any line stalls. With no request pending, the stall output and the burst start output are low.
- R2: A read that hits keeps stall low and presents the addressed word on the read data output in that same cycle.
- R3: A write that hits keeps stall low and updates the word so that later reads return it. It starts no memory burst.
- R4: A miss raises stall and starts one read burst. The burst address is the missed line's address with the offset and byte bits zero, and the burst length equals the line's word count. After the stall is released, the retried read returns the memory contents.
- R5: When the victim is valid and dirty, a write burst of the victim's line comes first, at the victim's own tag and set. It finishes before the read burst starts, and memory then holds the words written into that line.
- R6: A valid but clean victim, including any line that was only refilled and never written, is replaced without a write burst.
- R7: The victim within a set is an invalid way if one exists. Otherwise it is the way whose last hit lies furthest in the past.
- R8: A write miss stalls, refills the line from memory, and then applies the store. The other words of the line keep their memory values, and a later eviction writes the stored word back.
- R9: In the cycle after a read burst's done pulse, stall is still high.
- R10: With the default parameters the address fields are: bits 23..7 tag, bits 6..4 set, bits 3..2 word, bits 1..0 ignored. Evictions in one set leave the lines of other sets resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears valid and dirty flags and the controller |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Physical byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_stall | output | 1 | Processor must hold its request and wait |
| cpu_rdata | output | DATA_W | Load data, valid when a read request sees stall low |
| mem_start | output | 1 | One-cycle pulse opening a burst |
| mem_wr | output | 1 | Burst direction, 1 = write to memory; held for the burst |
| mem_addr | output | ADDR_W | Line-aligned burst byte address; held for the burst |
| mem_len | output | LINE_BITS+1 | Words in the burst (one line) |
| mem_wdata | output | DATA_W | Current write-burst word |
| mem_ack | input | 1 | One word moves in this cycle |
| mem_rdata | input | DATA_W | Current read-burst word, taken when mem_ack is high |
| mem_done | input | 1 | Pulse closing the burst, after its last word |

## Verification
The properties assume that the processor holds its request, address and data steady while stall is high. They also assume that the memory never acknowledges in the start cycle, acknowledges exactly the burst length, and raises done only after the last word and only within a burst. The bench drives the processor through a task that keeps the request steady until a cycle with stall low. Its memory responder latches each burst on the start pulse, inserts idle cycles between words, and closes every burst with a single done pulse.

// File: rtl/cache_pkg.sv
package cache_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2,
      ST_RESP  = 2'd3
   } ctl_state_e;

endpackage

// File: rtl/cache_tag_array.sv
module cache_tag_array #(
   parameter int SET_BITS = 3,
   parameter int WAY_BITS = 1,
   parameter int TAG_W    = 17
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [SET_BITS-1:0]            rd_set,
   output logic [(1<<WAY_BITS)-1:0][TAG_W-1:0] rd_tag,
   output logic [(1<<WAY_BITS)-1:0]       rd_valid,
   output logic [(1<<WAY_BITS)-1:0]       rd_dirty,
   input  logic                           fill_en,
   input  logic [SET_BITS-1:0]            fill_set,
   input  logic [((WAY_BITS>0)?WAY_BITS:1)-1:0] fill_way,
   input  logic [TAG_W-1:0]               fill_tag,
   input  logic                           dirty_en,
   input  logic [SET_BITS-1:0]            dirty_set,
   input  logic [((WAY_BITS>0)?WAY_BITS:1)-1:0] dirty_way
);

   localparam int SETS = 1 << SET_BITS;
   localparam int WAYS = 1 << WAY_BITS;

   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [WAYS-1:0]  vld_q [SETS];
   logic [WAYS-1:0]  dty_q [SETS];

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            dty_q[s] <= '0;
         end
      end else begin
         if (fill_en) begin
            vld_q[fill_set][fill_way] <= 1'b1;
            dty_q[fill_set][fill_way] <= 1'b0;
         end
         if (dirty_en) dty_q[dirty_set][dirty_way] <= 1'b1;
      end
   end

   always_comb begin
      for (int w = 0; w < WAYS; w++) rd_tag[w] = tag_q[rd_set][w];
      rd_valid = vld_q[rd_set];
      rd_dirty = dty_q[rd_set];
   end

endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
   parameter int SET_BITS = 3,
   parameter int WAY_BITS = 1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  touch_en,
   input  logic [SET_BITS-1:0]                   touch_set,
   input  logic [((WAY_BITS>0)?WAY_BITS:1)-1:0]  touch_way,
   input  logic [SET_BITS-1:0]                   look_set,
   input  logic [(1<<WAY_BITS)-1:0]              look_valid,
   output logic [((WAY_BITS>0)?WAY_BITS:1)-1:0]  victim_way
);

   localparam int SETS = 1 << SET_BITS;
   localparam int WAYS = 1 << WAY_BITS;
   localparam int WAY_IW = (WAY_BITS > 0) ? WAY_BITS : 1;

   generate
      if (WAY_BITS == 0) begin : g_direct
         logic unused_lru_inputs;
         assign unused_lru_inputs = ^{clk, rst_n, touch_en, touch_set, touch_way,
                                      look_set, look_valid};
         assign victim_way = '0;
      end else begin : g_ages
         // age 0 = most recent; age WAYS-1 = least recent; a permutation per set
         logic [WAY_BITS-1:0] age_q [SETS][WAYS];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SETS; s++)
                  for (int w = 0; w < WAYS; w++)
                     age_q[s][w] <= WAY_BITS'(w);
            end else if (touch_en) begin
               for (int w = 0; w < WAYS; w++) begin
                  if (WAY_IW'(w) == touch_way)
                     age_q[touch_set][w] <= '0;
                  else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                     age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
               end
            end
         end

         always_comb begin
            victim_way = '0;
            for (int w = 0; w < WAYS; w++)
               if (age_q[look_set][w] == WAY_BITS'(WAYS - 1)) victim_way = WAY_IW'(w);
            for (int w = WAYS - 1; w >= 0; w--)
               if (!look_valid[w]) victim_way = WAY_IW'(w);
         end
      end
   endgenerate

endmodule

// File: rtl/cache_data_array.sv
module cache_data_array #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] word_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) word_q[waddr] <= wdata;
   end

   assign rdata = word_q[raddr];

endmodule

// File: rtl/sa_wb_cache.sv
module sa_wb_cache #(
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 32,
   parameter int WAY_BITS  = 1,
   parameter int SET_BITS  = 3,
   parameter int LINE_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cpu_req,
   input  logic                 cpu_we,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [DATA_W-1:0]    cpu_wdata,
   output logic                 cpu_stall,
   output logic [DATA_W-1:0]    cpu_rdata,
   output logic                 mem_start,
   output logic                 mem_wr,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [LINE_BITS:0]   mem_len,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic                 mem_ack,
   input  logic [DATA_W-1:0]    mem_rdata,
   input  logic                 mem_done
);

   import cache_pkg::*;

   localparam int BYTE_BITS = $clog2(DATA_W / 8);
   localparam int OFF_LSB   = BYTE_BITS;
   localparam int SET_LSB   = OFF_LSB + LINE_BITS;
   localparam int TAG_LSB   = SET_LSB + SET_BITS;
   localparam int TAG_W     = ADDR_W - TAG_LSB;
   localparam int WAYS      = 1 << WAY_BITS;
   localparam int WORDS     = 1 << LINE_BITS;
   localparam int LEN_W     = LINE_BITS + 1;
   localparam int WAY_IW    = (WAY_BITS > 0) ? WAY_BITS : 1;
   localparam int IDX_W     = SET_BITS + WAY_IW + LINE_BITS;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0 || BYTE_BITS < 1) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes, at least two");
      end
      if (LINE_BITS < 1 || SET_BITS < 1 || WAY_BITS < 0) begin : g_bad_geom
         $error("LINE_BITS and SET_BITS must be at least 1, WAY_BITS non-negative");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("address too narrow for the chosen set and line sizes");
      end
   endgenerate

   // ---------------- address split ----------------
   logic [TAG_W-1:0]     req_tag;
   logic [SET_BITS-1:0]  req_set;
   logic [LINE_BITS-1:0] req_word;
   logic                 unused_byte_lane;

   assign req_tag          = cpu_addr[ADDR_W-1:TAG_LSB];
   assign req_set          = cpu_addr[TAG_LSB-1:SET_LSB];
   assign req_word         = cpu_addr[SET_LSB-1:OFF_LSB];
   assign unused_byte_lane = ^cpu_addr[OFF_LSB-1:0];

   // ---------------- controller state ----------------
   ctl_state_e           state_q;
   logic [SET_BITS-1:0]  miss_set_q;
   logic [WAY_IW-1:0]    miss_way_q;
   logic [TAG_W-1:0]     miss_tag_q;
   logic [TAG_W-1:0]     vict_tag_q;
   logic [LINE_BITS-1:0] beat_q;
   logic                 live_q;

   // ---------------- tag store ----------------
   logic [WAYS-1:0][TAG_W-1:0] rd_tag;
   logic [WAYS-1:0]            rd_valid;
   logic [WAYS-1:0]            rd_dirty;
   logic                       fill_en;
   logic                       wr_hit;
   logic [WAYS-1:0]            way_hit;
   logic [WAY_IW-1:0]          hit_way;
   logic [WAY_IW-1:0]          victim_way;
   logic                       lookup_hit;
   logic                       idle_hit;

   assign fill_en = (state_q == ST_FILL) && mem_done;

   cache_tag_array #(
      .SET_BITS (SET_BITS),
      .WAY_BITS (WAY_BITS),
      .TAG_W    (TAG_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_set    (req_set),
      .rd_tag    (rd_tag),
      .rd_valid  (rd_valid),
      .rd_dirty  (rd_dirty),
      .fill_en   (fill_en),
      .fill_set  (miss_set_q),
      .fill_way  (miss_way_q),
      .fill_tag  (miss_tag_q),
      .dirty_en  (wr_hit),
      .dirty_set (req_set),
      .dirty_way (hit_way)
   );

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_cmp
         assign way_hit[w] = rd_valid[w] && (rd_tag[w] == req_tag);
      end
   endgenerate

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (way_hit[w]) hit_way = WAY_IW'(w);
   end

   assign lookup_hit = cpu_req && (|way_hit);
   assign idle_hit   = (state_q == ST_IDLE) && lookup_hit;
   assign wr_hit     = idle_hit && cpu_we;

   // ---------------- replacement order ----------------
   cache_lru #(
      .SET_BITS (SET_BITS),
      .WAY_BITS (WAY_BITS)
   ) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (idle_hit),
      .touch_set  (req_set),
      .touch_way  (hit_way),
      .look_set   (req_set),
      .look_valid (rd_valid),
      .victim_way (victim_way)
   );

   // ---------------- data store ----------------
   logic              da_we;
   logic [IDX_W-1:0]  da_waddr;
   logic [DATA_W-1:0] da_wdata;
   logic [IDX_W-1:0]  da_raddr;
   logic [DATA_W-1:0] da_rdata;

   always_comb begin
      da_we    = 1'b0;
      da_waddr = {req_set, hit_way, req_word};
      da_wdata = cpu_wdata;
      if (state_q == ST_FILL && mem_ack) begin
         da_we    = 1'b1;
         da_waddr = {miss_set_q, miss_way_q, beat_q};
         da_wdata = mem_rdata;
      end else if (wr_hit) begin
         da_we    = 1'b1;
      end
   end

   assign da_raddr = (state_q == ST_WBACK) ? {miss_set_q, miss_way_q, beat_q}
                                           : {req_set, hit_way, req_word};

   cache_data_array #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_data (
      .clk   (clk),
      .we    (da_we),
      .waddr (da_waddr),
      .wdata (da_wdata),
      .raddr (da_raddr),
      .rdata (da_rdata)
   );

   // ---------------- miss sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         miss_set_q <= '0;
         miss_way_q <= '0;
         miss_tag_q <= '0;
         vict_tag_q <= '0;
         beat_q     <= '0;
         live_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (cpu_req && !(|way_hit)) begin
                  miss_set_q <= req_set;
                  miss_tag_q <= req_tag;
                  miss_way_q <= victim_way;
                  vict_tag_q <= rd_tag[victim_way];
                  beat_q     <= '0;
                  state_q    <= (rd_valid[victim_way] && rd_dirty[victim_way])
                                ? ST_WBACK : ST_FILL;
               end
            end
            ST_WBACK, ST_FILL: begin
               if (!live_q) live_q <= 1'b1;
               if (mem_ack) beat_q <= beat_q + 1'b1;
               if (mem_done) begin
                  live_q  <= 1'b0;
                  beat_q  <= '0;
                  state_q <= (state_q == ST_WBACK) ? ST_FILL : ST_RESP;
               end
            end
            ST_RESP: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- outputs ----------------
   assign cpu_stall = (state_q != ST_IDLE) || (cpu_req && !(|way_hit));
   assign cpu_rdata = da_rdata;
   assign mem_start = ((state_q == ST_WBACK) || (state_q == ST_FILL)) && !live_q;
   assign mem_wr    = (state_q == ST_WBACK);
   assign mem_addr  = {(state_q == ST_WBACK) ? vict_tag_q : miss_tag_q,
                       miss_set_q, {SET_LSB{1'b0}}};
   assign mem_len   = LEN_W'(WORDS);
   assign mem_wdata = da_rdata;

endmodule

// File: rtl/sa_wb_cache_chk.sv
module sa_wb_cache_chk #(
   parameter int OFF_W = 4,
   parameter int LEN_W = 3,
   parameter int WORDS = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cpu_req,
   input logic                  cpu_stall,
   input logic                  mem_start,
   input logic                  mem_wr,
   input logic [OFF_W-1:0]      line_off,
   input logic [LEN_W-1:0]      mem_len,
   input logic                  mem_done,
   input logic                  lookup_hit,
   input cache_pkg::ctl_state_e state_q
);

   p_hit_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == cache_pkg::ST_IDLE && lookup_hit) |-> !cpu_stall);

   p_miss_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !lookup_hit) |-> cpu_stall);

   p_start_stalled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_start |-> cpu_stall);

   p_line_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_start |-> (line_off == '0 && mem_len == LEN_W'(WORDS)));

   p_refill_after_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_done && mem_wr) |=> (mem_start && !mem_wr));

   p_resp_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_done && !mem_wr) |=> cpu_stall);

endmodule

bind sa_wb_cache sa_wb_cache_chk #(
   .OFF_W (SET_LSB),
   .LEN_W (LEN_W),
   .WORDS (WORDS)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_req    (cpu_req),
   .cpu_stall  (cpu_stall),
   .mem_start  (mem_start),
   .mem_wr     (mem_wr),
   .line_off   (mem_addr[SET_LSB-1:0]),
   .mem_len    (mem_len),
   .mem_done   (mem_done),
   .lookup_hit (lookup_hit),
   .state_q    (state_q)
);

// File: tb/test_sa_wb_cache.sv
`timescale 1ns/1ps
module test_sa_wb_cache;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [23:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_stall;
   logic [31:0] cpu_rdata;
   logic        mem_start;
   logic        mem_wr;
   logic [23:0] mem_addr;
   logic [2:0]  mem_len;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_done = 1'b0;

   always #2.5 clk = ~clk;

   sa_wb_cache i_sa_wb_cache (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_stall(cpu_stall), .cpu_rdata(cpu_rdata),
      .mem_start(mem_start), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_len(mem_len),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_done(mem_done)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // ---------------- memory model and reference image ----------------
   logic [31:0] mem_img [int];
   logic [31:0] view    [int];

   function automatic logic [31:0] init_val(input int w);
      logic [31:0] x;
      x = w;
      return (x * 32'd2654435) ^ 32'h3C00_0000;
   endfunction

   function automatic logic [31:0] mem_rd(input int w);
      if (mem_img.exists(w)) return mem_img[w];
      return init_val(w);
   endfunction

   function automatic logic [31:0] exp_rd(input int w);
      if (view.exists(w)) return view[w];
      return init_val(w);
   endfunction

   // default config: tag [23:7], set [6:4], word [3:2], byte [1:0]
   function automatic logic [23:0] mk(input int tg, input int st, input int wd);
      logic [16:0] t;
      logic [2:0]  s;
      logic [1:0]  d;
      t = tg[16:0];
      s = st[2:0];
      d = wd[1:0];
      return {t, s, d, 2'b00};
   endfunction

   int          rd_bursts = 0;
   int          wb_bursts = 0;
   int          burst_no  = 0;
   int          rd_seq    = 0;
   int          wb_seq    = 0;
   logic [23:0] last_rd_addr = '0;
   logic [23:0] last_wb_addr = '0;

   initial begin
      bit          busy = 0;
      bit          b_wr = 0;
      bit          resp_chk = 0;
      int          b_base = 0;
      int          b_len = 0;
      int          cnt = 0;
      int          gap = 0;
      forever begin
         @(negedge clk);
         if (resp_chk) begin
            chk(cpu_stall == 1'b1, "R9", "stall in cycle after refill done", {31'd0, cpu_stall}, 32'd1);
            resp_chk = 0;
         end
         mem_ack  = 1'b0;
         mem_done = 1'b0;
         if (!busy) begin
            if (rst_n && mem_start) begin
               busy   = 1;
               b_wr   = mem_wr;
               b_base = int'(mem_addr[23:2]);
               b_len  = int'(mem_len);
               cnt    = 0;
               gap    = 1;
               burst_no++;
               if (b_wr) begin
                  wb_bursts++;
                  wb_seq = burst_no;
                  last_wb_addr = mem_addr;
               end else begin
                  rd_bursts++;
                  rd_seq = burst_no;
                  last_rd_addr = mem_addr;
               end
            end
         end else if (cnt < b_len) begin
            if (gap > 0) gap--;
            else begin
               mem_ack = 1'b1;
               if (b_wr) mem_img[b_base + cnt] = mem_wdata;
               else      mem_rdata = mem_rd(b_base + cnt);
               cnt++;
               gap = cnt % 2;
            end
         end else begin
            mem_done = 1'b1;
            busy = 0;
            if (!b_wr) resp_chk = 1;
         end
      end
   end

   // ---------------- processor access ----------------
   task automatic access(input bit we, input logic [23:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output bit stalled);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      #1;
      stalled = 0;
      while (cpu_stall) begin
         stalled = 1;
         @(negedge clk);
         #1;
      end
      rd = cpu_rdata;
      if (we) view[int'(a[23:2])] = wd;
      @(posedge clk);
      #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic rd_expect(input logic [23:0] a, input bit exp_stall, input string rq);
      logic [31:0] d;
      bit          st;
      access(1'b0, a, '0, d, st);
      chk(st == exp_stall, rq, "stall seen on read", {31'd0, st}, {31'd0, exp_stall});
      chk(d == exp_rd(int'(a[23:2])), rq, "read data", d, exp_rd(int'(a[23:2])));
   endtask

   localparam int T0 = 5, T1 = 9, T2 = 12, T3 = 3;

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int rb, wb;
      logic [31:0] d;
      bit st;

      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_stall == 1'b0, "R1", "stall idle after reset", {31'd0, cpu_stall}, 32'd0);
      chk(mem_start == 1'b0, "R1", "no burst after reset", {31'd0, mem_start}, 32'd0);

      // sweep: every set, two tags, every word
      for (int s = 0; s < 8; s++) begin
         for (int k = 0; k < 2; k++) begin
            int t;
            t  = (k == 0) ? T0 : T1;
            rb = rd_bursts;
            for (int w = 0; w < 4; w++)
               rd_expect(mk(t, s, w), (w == 0), (w == 0) ? "R1" : "R2");
            chk(rd_bursts == rb + 1, "R4", "one refill per line", rd_bursts, rb + 1);
            chk(last_rd_addr == mk(t, s, 0), "R4", "refill address aligned", {8'd0, last_rd_addr}, {8'd0, mk(t, s, 0)});
         end
      end
      chk(wb_bursts == 0, "R6", "no write-back of clean lines", wb_bursts, 0);

      // write hits in set 0, tag T0
      rb = rd_bursts; wb = wb_bursts;
      for (int w = 0; w < 4; w++) begin
         access(1'b1, mk(T0, 0, w), 32'hD000_0000 + w, d, st);
         chk(st == 0, "R3", "write hit no stall", {31'd0, st}, 32'd0);
      end
      chk(rd_bursts == rb && wb_bursts == wb, "R3", "no memory traffic on write hit", rd_bursts + wb_bursts, rb + wb);
      for (int w = 0; w < 4; w++) rd_expect(mk(T0, 0, w), 1'b0, "R3");
      chk(mem_rd(int'(mk(T0, 0, 1) >> 2)) == init_val(int'(mk(T0, 0, 1) >> 2)), "R3",
          "memory untouched by write hit", mem_rd(int'(mk(T0, 0, 1) >> 2)), init_val(int'(mk(T0, 0, 1) >> 2)));

      // replacement order in set 0
      rd_expect(mk(T1, 0, 0), 1'b0, "R7");
      rd_expect(mk(T0, 0, 0), 1'b0, "R7");
      wb = wb_bursts;
      rd_expect(mk(T2, 0, 0), 1'b1, "R7");
      chk(wb_bursts == wb, "R6", "clean victim evicted silently", wb_bursts, wb);
      rd_expect(mk(T0, 0, 1), 1'b0, "R7");
      rd_expect(mk(T1, 0, 0), 1'b1, "R7");
      chk(wb_bursts == wb, "R6", "refilled line evicted silently", wb_bursts, wb);
      // set 0 now {T0 dirty (older), T1}; T2 evicts T0
      rb = rd_bursts;
      rd_expect(mk(T2, 0, 3), 1'b1, "R5");
      chk(wb_bursts == wb + 1, "R5", "one write-back", wb_bursts, wb + 1);
      chk(last_wb_addr == mk(T0, 0, 0), "R5", "write-back address", {8'd0, last_wb_addr}, {8'd0, mk(T0, 0, 0)});
      chk(rd_seq == wb_seq + 1 && rd_bursts == rb + 1, "R5", "refill after write-back", rd_seq, wb_seq + 1);
      for (int w = 0; w < 4; w++)
         chk(mem_rd(int'(mk(T0, 0, w) >> 2)) == 32'hD000_0000 + w, "R5", "written-back word",
             mem_rd(int'(mk(T0, 0, w) >> 2)), 32'hD000_0000 + w);
      rd_expect(mk(T0, 0, 2), 1'b1, "R5");

      // write miss in set 3 (holds T0 older, T1)
      wb = wb_bursts; rb = rd_bursts;
      access(1'b1, mk(T3, 3, 1), 32'hBEEF_0001, d, st);
      chk(st == 1, "R8", "write miss stalls", {31'd0, st}, 32'd1);
      chk(wb_bursts == wb && rd_bursts == rb + 1, "R8", "refill only", rd_bursts, rb + 1);
      chk(last_rd_addr == mk(T3, 3, 0), "R8", "refill address", {8'd0, last_rd_addr}, {8'd0, mk(T3, 3, 0)});
      rd_expect(mk(T3, 3, 1), 1'b0, "R8");
      rd_expect(mk(T3, 3, 0), 1'b0, "R8");
      rd_expect(mk(T0, 3, 0), 1'b1, "R7");
      chk(wb_bursts == wb, "R6", "clean T1 evicted silently", wb_bursts, wb);
      rd_expect(mk(T1, 3, 0), 1'b1, "R8");
      chk(wb_bursts == wb + 1 && last_wb_addr == mk(T3, 3, 0), "R8", "stored line written back",
          {8'd0, last_wb_addr}, {8'd0, mk(T3, 3, 0)});
      chk(mem_rd(int'(mk(T3, 3, 1) >> 2)) == 32'hBEEF_0001, "R8", "stored word in memory",
          mem_rd(int'(mk(T3, 3, 1) >> 2)), 32'hBEEF_0001);

      // other sets untouched
      rb = rd_bursts;
      for (int w = 0; w < 4; w++) begin
         rd_expect(mk(T0, 7, w), 1'b0, "R10");
         rd_expect(mk(T1, 5, w), 1'b0, "R10");
      end
      chk(rd_bursts == rb, "R10", "no refill in untouched sets", rd_bursts, rb);

      repeat (4) @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule